// File: doc/BRIEF.md
# Arithmetic Execution Unit for a 64-bit Register-Machine Instruction Set

This block executes the arithmetic instructions of a 64-bit register-machine instruction set. A sequencer presents an 8-bit opcode, a 16-bit offset, a 32-bit immediate and the current values of the destination and source registers, and pulses `start_i`. The unit decodes the operation, picks the second operand, computes the value to write back to the destination register and reports it with a one-cycle `done_o` pulse. `illegal_o` is raised together with `done_o` when the encoding is not a defined arithmetic instruction. In that case the register file must not be written.

Single-cycle operations cover add, subtract, multiply, the logic operations, shifts, negate, move, sign-extending move and byte swap. They finish on the clock edge that accepts them. Divide and modulo with a non-zero divisor use an iterative radix-2 divider on operand magnitudes, with the sign applied afterwards. While the divider runs, `busy_o` is high and new starts are ignored. Division and modulo by zero bypass the divider and finish in one cycle.

Top module: `alu_ex_unit`

## Requirements
- R1: Opcode bits [2:0] select the class: 3'h4 is the 32-bit class and 3'h7 is the 64-bit class. Any other class is illegal. Bit 3 selects the second operand: 0 uses the immediate and 1 uses `src_i`. Bits [7:4] are the operation code. In the 64-bit class the immediate is sign-extended to 64 bits for every operation, unsigned divide and modulo included. In the 32-bit class it is taken as an unsigned 32-bit value.
- R2: Operation codes 0x0 add, 0x1 subtract, 0x2 multiply (low half of the product), 0x4 or, 0x5 and, 0xa xor, 0xb move (offset 0) and 0x8 negate (`-dst`) all wrap on overflow. In the 32-bit class they act on the low 32 bits and the upper 32 result bits are zero.
- R3: Code 0x6 shifts left, code 0x7 shifts right logically and code 0xc shifts right arithmetically, filling with the sign bit. The shift amount is the second operand masked to 6 bits in the 64-bit class and to 5 bits in the 32-bit class.
- R4: Codes 0x3 (divide) and 0x9 (modulo) with offset 0 are unsigned.
- R5: Codes 0x3 and 0x9 with offset 1 are signed and truncate toward zero, so -13 mod 3 is -1. The most negative value divided by -1 wraps to the most negative value, and its remainder is 0.
- R6: Divide by zero returns 0. Modulo by zero returns the destination unchanged in the 64-bit class, and its low 32 bits zero-extended in the 32-bit class. Both finish one cycle after the start.
- R7: Code 0xb with a register source and offset 8, 16 or 32 sign-extends the low 8, 16 or 32 bits of `src_i` to 64 bits. The 32-bit class allows only offsets 8 and 16; it sign-extends to 32 bits and zeroes the upper half.
- R8: Code 0xd swaps bytes of the destination only, with width given by the immediate (16, 32 or 64). In the 32-bit class, source bit 0 keeps the low width bits zero-extended with no reordering, and source bit 1 reverses the bytes within the width and zero-extends. In the 64-bit class the bytes are always reversed, and source bit 1 is illegal. A 64-bit width returns all 64 bits, even in the 32-bit class.
- R9: An undefined encoding finishes in one cycle with `illegal_o`=1 and `result_o`=0. The undefined encodings are:
  - operation codes 0xe and 0xf;
  - a non-zero offset outside the forms listed above;
  - negate with source bit 1;
  - a sign-extending move with the immediate source or with a disallowed width;
  - a byte swap with an immediate other than 16, 32 or 64.
- R10: `done_o` is a one-cycle pulse. Every operation other than divide or modulo with a non-zero divisor shows `done_o` one cycle after `start_i`. A divide holds `busy_o` high until its `done_o`. A `start_i` while `busy_o` is high is ignored and produces no `done_o`.
- R11: Synchronous active-high reset clears `done_o`, `illegal_o`, `busy_o` and `result_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin executing the presented instruction |
| opcode_i | input | 8 | Operation code, operand select and class |
| offset_i | input | 16 | Offset field (selects signed and extending forms) |
| imm_i | input | 32 | Immediate field |
| dst_i | input | 64 | Destination register value |
| src_i | input | 64 | Source register value |
| busy_o | output | 1 | Divider in progress; starts are ignored |
| done_o | output | 1 | One-cycle pulse: result is valid |
| illegal_o | output | 1 | With done_o: encoding undefined, do not write |
| result_o | output | 64 | Value to write to the destination register |

## Verification
Properties check several things on every cycle:
- an illegal flag comes only with done and a zero result;
- done never coincides with busy;
- busy rises only after an accepted start;
- negate with a register source is flagged;
- 64-bit divide and modulo by zero give their fixed results one cycle later;
- 32-bit class results other than byte swaps have a clear upper half.

The arithmetic itself needs the bench's scenarios. Those cover signed truncation, the wrap of the most negative value, the sign-extending moves, the byte swaps, shift masking and the ignoring of a start during a divide. The bench compares each result against an independent model, over random encodings and operands.

// File: rtl/alu_ex_pkg.sv
package alu_ex_pkg;

  localparam logic [2:0] CLS_W32 = 3'h4;
  localparam logic [2:0] CLS_W64 = 3'h7;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0, OP_SUB  = 4'h1, OP_MUL  = 4'h2, OP_DIV  = 4'h3,
    OP_OR   = 4'h4, OP_AND  = 4'h5, OP_LSH  = 4'h6, OP_RSH  = 4'h7,
    OP_NEG  = 4'h8, OP_MOD  = 4'h9, OP_XOR  = 4'ha, OP_MOV  = 4'hb,
    OP_ARSH = 4'hc, OP_END  = 4'hd, OP_RSVE = 4'he, OP_RSVF = 4'hf
  } alu_op_e;

  // sign-extending move width
  typedef enum logic [1:0] {EXT_NONE = 2'd0, EXT_8 = 2'd1, EXT_16 = 2'd2, EXT_32 = 2'd3} ext_e;

  typedef struct packed {
    logic    legal;
    logic    is32;
    logic    use_reg;
    alu_op_e op;
    logic    sgn;
    ext_e    ext;
    logic [1:0] swap_w;   // 0: 16, 1: 32, 2: 64 bits
    logic    swap_rev;    // reverse bytes, else truncate only
  } dec_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_DIV = 1'b1} state_e;

endpackage

// File: rtl/alu_ex_decode.sv
module alu_ex_decode
  import alu_ex_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32,
  parameter int OFF_W  = 16
) (
  input  logic [7:0]        opcode_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] src_i,
  output dec_t              dec_o,
  output logic [DATA_W-1:0] opb_o
);
  logic arith, off0, off1, off8, off16, off32, iw16, iw32, iw64;
  logic ok;

  assign off0  = (offset_i == OFF_W'(0));
  assign off1  = (offset_i == OFF_W'(1));
  assign off8  = (offset_i == OFF_W'(8));
  assign off16 = (offset_i == OFF_W'(16));
  assign off32 = (offset_i == OFF_W'(32));
  assign iw16  = (imm_i == IMM_W'(16));
  assign iw32  = (imm_i == IMM_W'(32));
  assign iw64  = (imm_i == IMM_W'(64));
  assign arith = (opcode_i[2:0] == CLS_W32) || (opcode_i[2:0] == CLS_W64);

  always_comb begin
    dec_o          = '0;
    dec_o.is32     = (opcode_i[2:0] == CLS_W32);
    dec_o.use_reg  = opcode_i[3];
    dec_o.op       = alu_op_e'(opcode_i[7:4]);
    ok             = off0;
    unique case (dec_o.op)
      OP_DIV, OP_MOD: begin
        ok        = off0 || off1;
        dec_o.sgn = off1;
      end
      OP_NEG: ok = off0 && !dec_o.use_reg;
      OP_MOV: begin
        ok = off0 || (dec_o.use_reg && (off8 || off16 || (off32 && !dec_o.is32)));
        if (off8)       dec_o.ext = EXT_8;
        else if (off16) dec_o.ext = EXT_16;
        else if (off32) dec_o.ext = EXT_32;
        else            dec_o.ext = EXT_NONE;
      end
      OP_END: begin
        ok = off0 && (iw16 || iw32 || iw64) && (dec_o.is32 || !dec_o.use_reg);
        dec_o.swap_w   = iw64 ? 2'd2 : (iw32 ? 2'd1 : 2'd0);
        dec_o.swap_rev = !dec_o.is32 || dec_o.use_reg;
      end
      OP_RSVE, OP_RSVF: ok = 1'b0;
      default: ok = off0;
    endcase
    dec_o.legal = ok && arith;
  end

  always_comb begin
    if (opcode_i[3])                   opb_o = src_i;
    else if (opcode_i[2:0] == CLS_W32) opb_o = {{(DATA_W-IMM_W){1'b0}}, imm_i};
    else                               opb_o = {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  end

endmodule

// File: rtl/alu_ex_simple.sv
module alu_ex_simple
  import alu_ex_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  dec_t              dec_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int HW   = DATA_W / 2;
  localparam int SH_W = $clog2(DATA_W);
  localparam int NSW  = 3;

  logic [HW-1:0]     a_lo, b_lo, half;
  logic [DATA_W-1:0] full, ext_v;
  logic [SH_W-1:0]   sh_f;
  logic [SH_W-2:0]   sh_h;
  logic [DATA_W-1:0] swapped [NSW];
  logic [DATA_W-1:0] trunc   [NSW];

  assign a_lo = opa_i[HW-1:0];
  assign b_lo = opb_i[HW-1:0];
  assign sh_f = opb_i[SH_W-1:0];
  assign sh_h = opb_i[SH_W-2:0];

  // byte reorder and truncation for widths 16, 32, 64
  for (genvar k = 0; k < NSW; k++) begin : g_sw
    localparam int NB = 2 << k;
    for (genvar g = 0; g < DATA_W / 8; g++) begin : g_by
      if (g < NB) begin : g_in
        assign swapped[k][8*g +: 8] = opa_i[8*(NB-1-g) +: 8];
        assign trunc[k][8*g +: 8]   = opa_i[8*g +: 8];
      end else begin : g_out
        assign swapped[k][8*g +: 8] = 8'h00;
        assign trunc[k][8*g +: 8]   = 8'h00;
      end
    end
  end

  always_comb begin
    unique case (dec_i.ext)
      EXT_8:   ext_v = {{(DATA_W-8){opb_i[7]}}, opb_i[7:0]};
      EXT_16:  ext_v = {{(DATA_W-16){opb_i[15]}}, opb_i[15:0]};
      EXT_32:  ext_v = {{(DATA_W-32){opb_i[31]}}, opb_i[31:0]};
      default: ext_v = opb_i;
    endcase
  end

  always_comb begin
    full = '0;
    half = '0;
    unique case (dec_i.op)
      OP_ADD:  begin full = opa_i + opb_i;  half = a_lo + b_lo;  end
      OP_SUB:  begin full = opa_i - opb_i;  half = a_lo - b_lo;  end
      OP_MUL:  begin full = opa_i * opb_i;  half = a_lo * b_lo;  end
      OP_OR:   begin full = opa_i | opb_i;  half = a_lo | b_lo;  end
      OP_AND:  begin full = opa_i & opb_i;  half = a_lo & b_lo;  end
      OP_XOR:  begin full = opa_i ^ opb_i;  half = a_lo ^ b_lo;  end
      OP_NEG:  begin full = -opa_i;         half = -a_lo;        end
      OP_LSH:  begin full = opa_i << sh_f;  half = a_lo << sh_h; end
      OP_RSH:  begin full = opa_i >> sh_f;  half = a_lo >> sh_h; end
      OP_ARSH: begin
        full = DATA_W'($signed(opa_i) >>> sh_f);
        half = HW'($signed(a_lo) >>> sh_h);
      end
      OP_MOV:  begin full = ext_v;          half = ext_v[HW-1:0]; end
      OP_END:  begin
        full = dec_i.swap_rev ? swapped[dec_i.swap_w] : trunc[dec_i.swap_w];
        half = full[HW-1:0];
      end
      default: begin full = '0; half = '0; end
    endcase
  end

  // byte swap keeps its full width; other 32-bit results clear the upper half
  assign res_o = (dec_i.is32 && dec_i.op != OP_END) ? {{HW{1'b0}}, half} : full;

endmodule

// File: rtl/alu_ex_divider.sv
module alu_ex_divider #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0] divisor_i,
  output logic              done_o,
  output logic [DATA_W-1:0] quot_o,
  output logic [DATA_W-1:0] rem_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] dvs;
  logic [DATA_W:0]   trial, diff;
  logic              ge;

  assign trial = {rem_o, quot_o[DATA_W-1]};
  assign diff  = trial - {1'b0, dvs};
  assign ge    = (trial >= {1'b0, dvs});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      dvs    <= '0;
      quot_o <= '0;
      rem_o  <= '0;
      done_o <= 1'b0;
    end else if (start_i) begin
      cnt    <= CNT_W'(DATA_W);
      dvs    <= divisor_i;
      quot_o <= dividend_i;
      rem_o  <= '0;
      done_o <= 1'b0;
    end else if (cnt != '0) begin
      rem_o  <= ge ? diff[DATA_W-1:0] : trial[DATA_W-1:0];
      quot_o <= {quot_o[DATA_W-2:0], ge};
      cnt    <= cnt - 1'b1;
      done_o <= (cnt == CNT_W'(1));
    end else begin
      done_o <= 1'b0;
    end
  end

endmodule

// File: rtl/alu_ex_unit.sv
module alu_ex_unit
  import alu_ex_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int HW = DATA_W / 2;

  dec_t              dec;
  state_e            state;
  logic [DATA_W-1:0] opb, simple_res, ea, eb, mag_a, mag_b, zero_res;
  logic [DATA_W-1:0] quot, rem, q_fix, r_fix, pick, fin;
  logic              is_div, bzero, accept, div_go, div_done;
  logic              p_mod, p_32, p_nq, p_nr;

  alu_ex_decode #(.DATA_W(DATA_W), .IMM_W(IMM_W), .OFF_W(OFF_W)) u_dec (
    .opcode_i(opcode_i), .offset_i(offset_i), .imm_i(imm_i), .src_i(src_i),
    .dec_o(dec), .opb_o(opb)
  );

  alu_ex_simple #(.DATA_W(DATA_W)) u_simple (
    .dec_i(dec), .opa_i(dst_i), .opb_i(opb), .res_o(simple_res)
  );

  assign is_div = (dec.op == OP_DIV) || (dec.op == OP_MOD);
  assign bzero  = dec.is32 ? (opb[HW-1:0] == '0) : (opb == '0);
  assign busy_o = (state == ST_DIV);
  assign accept = start_i && !busy_o;
  assign div_go = accept && dec.legal && is_div && !bzero;

  // widen 32-bit operands per signedness, then take magnitudes
  always_comb begin
    if (dec.is32) begin
      ea = {{HW{dec.sgn & dst_i[HW-1]}}, dst_i[HW-1:0]};
      eb = {{HW{dec.sgn & opb[HW-1]}}, opb[HW-1:0]};
    end else begin
      ea = dst_i;
      eb = opb;
    end
    mag_a = (dec.sgn && ea[DATA_W-1]) ? -ea : ea;
    mag_b = (dec.sgn && eb[DATA_W-1]) ? -eb : eb;
  end

  assign zero_res = (dec.op == OP_DIV) ? '0 :
                    (dec.is32 ? {{HW{1'b0}}, dst_i[HW-1:0]} : dst_i);

  alu_ex_divider #(.DATA_W(DATA_W)) u_div (
    .clk(clk), .rst(rst), .start_i(div_go),
    .dividend_i(mag_a), .divisor_i(mag_b),
    .done_o(div_done), .quot_o(quot), .rem_o(rem)
  );

  assign q_fix = p_nq ? -quot : quot;
  assign r_fix = p_nr ? -rem : rem;
  assign pick  = p_mod ? r_fix : q_fix;
  assign fin   = p_32 ? {{HW{1'b0}}, pick[HW-1:0]} : pick;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      result_o  <= '0;
      p_mod     <= 1'b0;
      p_32      <= 1'b0;
      p_nq      <= 1'b0;
      p_nr      <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          if (!dec.legal) begin
            done_o    <= 1'b1;
            illegal_o <= 1'b1;
            result_o  <= '0;
          end else if (div_go) begin
            state <= ST_DIV;
            p_mod <= (dec.op == OP_MOD);
            p_32  <= dec.is32;
            p_nq  <= dec.sgn && (ea[DATA_W-1] ^ eb[DATA_W-1]);
            p_nr  <= dec.sgn && ea[DATA_W-1];
          end else if (is_div) begin
            done_o   <= 1'b1;
            result_o <= zero_res;
          end else begin
            done_o   <= 1'b1;
            result_o <= simple_res;
          end
        end
        ST_DIV: if (div_done) begin
          done_o   <= 1'b1;
          result_o <= fin;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/alu_ex_chk.sv
module alu_ex_chk #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32,
  parameter int OFF_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [7:0]        opcode_i,
  input logic [OFF_W-1:0]  offset_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic [DATA_W-1:0] dst_i,
  input logic [DATA_W-1:0] src_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              illegal_o,
  input logic [DATA_W-1:0] result_o
);
  localparam int HW = DATA_W / 2;

  logic              acc, c64, dm_off, lat_half;
  logic [DATA_W-1:0] b64;

  assign acc    = start_i && !busy_o;
  assign c64    = (opcode_i[2:0] == 3'h7);
  assign dm_off = (offset_i == OFF_W'(0)) || (offset_i == OFF_W'(1));
  assign b64    = opcode_i[3] ? src_i : {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};

  always_ff @(posedge clk) begin
    if (rst) lat_half <= 1'b0;
    else if (acc) lat_half <= (opcode_i[2:0] == 3'h4) && (opcode_i[7:4] != 4'hd);
  end

  AST_ILLEGAL_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> done_o);                                                  // R9
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (result_o == '0));                                        // R9
  AST_NEG_REG_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    (acc && (opcode_i[2:0] == 3'h4 || c64) && opcode_i[7:3] == 5'b10001)
    |=> (done_o && illegal_o));                                             // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);                                                    // R10
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));                                      // R10
  AST_DIV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (acc && c64 && opcode_i[7:4] == 4'h3 && dm_off && b64 == '0)
    |=> (done_o && !illegal_o && result_o == '0));                          // R6
  AST_MOD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (acc && c64 && opcode_i[7:4] == 4'h9 && dm_off && b64 == '0)
    |=> (done_o && !illegal_o && result_o == $past(dst_i)));                // R6
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done_o && !illegal_o && lat_half) |-> (result_o[DATA_W-1:HW] == '0));  // R2

endmodule

bind alu_ex_unit alu_ex_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .opcode_i(opcode_i),
  .offset_i(offset_i), .imm_i(imm_i), .dst_i(dst_i), .src_i(src_i),
  .busy_o(busy_o), .done_o(done_o), .illegal_o(illegal_o), .result_o(result_o)
);

// File: tb/tb_alu_ex_unit.sv
`timescale 1ns/1ps
module tb_alu_ex_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [15:0] offset_i = '0;
  logic [31:0] imm_i = '0;
  logic [63:0] dst_i = '0, src_i = '0;
  logic        busy_o, done_o, illegal_o;
  logic [63:0] result_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;   // 250 MHz

  alu_ex_unit dut (
    .clk(clk), .rst(rst), .start_i(start_i), .opcode_i(opcode_i),
    .offset_i(offset_i), .imm_i(imm_i), .dst_i(dst_i), .src_i(src_i),
    .busy_o(busy_o), .done_o(done_o), .illegal_o(illegal_o), .result_o(result_o)
  );

  task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] bswapn(input logic [63:0] d, input int nb);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) if (i < nb) r[8*i +: 8] = d[8*(nb-1-i) +: 8];
    return r;
  endfunction

  // independent reference: returns {illegal, result}
  function automatic logic [64:0] model(input logic [7:0] op, input logic [15:0] off,
                                        input logic [31:0] imm, input logic [63:0] d,
                                        input logic [63:0] s);
    logic w32, x, ok;
    logic [3:0] c;
    logic [63:0] b, r;
    logic [31:0] t;
    longint sa, sv;
    int nb;
    x = op[3]; c = op[7:4]; ok = 1'b1; r = '0;
    if (op[2:0] == 3'h4) w32 = 1'b1;
    else if (op[2:0] == 3'h7) w32 = 1'b0;
    else return {1'b1, 64'h0};
    b = x ? s : (w32 ? {32'h0, imm} : {{32{imm[31]}}, imm});
    sa = w32 ? longint'($signed(d[31:0])) : longint'(d);
    sv = w32 ? longint'($signed(b[31:0])) : longint'(b);
    case (c)
      4'h0: begin ok = (off == 0); r = d + b; end
      4'h1: begin ok = (off == 0); r = d - b; end
      4'h2: begin ok = (off == 0); r = d * b; end
      4'h4: begin ok = (off == 0); r = d | b; end
      4'h5: begin ok = (off == 0); r = d & b; end
      4'ha: begin ok = (off == 0); r = d ^ b; end
      4'h8: begin ok = (off == 0) && !x; r = -d; end
      4'h6: begin ok = (off == 0); if (w32) begin t = d[31:0] << b[4:0]; r = {32'h0, t}; end else r = d << b[5:0]; end
      4'h7: begin ok = (off == 0); if (w32) begin t = d[31:0] >> b[4:0]; r = {32'h0, t}; end else r = d >> b[5:0]; end
      4'hc: begin
        ok = (off == 0);
        if (w32) begin t = $signed(d[31:0]) >>> b[4:0]; r = {32'h0, t}; end
        else r = $signed(d) >>> b[5:0];
      end
      4'h3, 4'h9: begin
        ok = (off == 0) || (off == 1);
        if (off == 1) begin
          if (sv == 0) r = (c == 4'h3) ? 64'h0 : d;
          else if (!w32 && sa == 64'sh8000000000000000 && sv == -1) r = (c == 4'h3) ? d : 64'h0;
          else r = (c == 4'h3) ? 64'(sa / sv) : 64'(sa % sv);
        end else if (w32) begin
          if (b[31:0] == 0) r = (c == 4'h3) ? 64'h0 : d;
          else r = (c == 4'h3) ? {32'h0, d[31:0] / b[31:0]} : {32'h0, d[31:0] % b[31:0]};
        end else begin
          if (b == 0) r = (c == 4'h3) ? 64'h0 : d;
          else r = (c == 4'h3) ? d / b : d % b;
        end
      end
      4'hb: begin
        if (off == 0) r = b;
        else if (x && off == 8)  r = {{56{s[7]}}, s[7:0]};
        else if (x && off == 16) r = {{48{s[15]}}, s[15:0]};
        else if (x && off == 32 && !w32) r = {{32{s[31]}}, s[31:0]};
        else ok = 1'b0;
      end
      4'hd: begin
        ok = (off == 0) && (imm == 16 || imm == 32 || imm == 64) && (w32 || !x);
        nb = int'(imm) / 8;
        if (w32 && !x) r = (nb == 8) ? d : (d & ((64'h1 << (8*nb)) - 64'h1));
        else r = bswapn(d, nb);
      end
      default: ok = 1'b0;
    endcase
    if (w32 && c != 4'hd) r = {32'h0, r[31:0]};
    return ok ? {1'b0, r} : {1'b1, 64'h0};
  endfunction

  task automatic run_op(input logic [7:0] op, input logic [15:0] off, input logic [31:0] imm,
                        input logic [63:0] d, input logic [63:0] s,
                        output logic [64:0] got, output int lat);
    @(negedge clk);
    opcode_i = op; offset_i = off; imm_i = imm; dst_i = d; src_i = s; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    got = {illegal_o, result_o};
  endtask

  task automatic dir(input string req, input logic [7:0] op, input logic [15:0] off,
                     input logic [31:0] imm, input logic [63:0] d, input logic [63:0] s,
                     input logic [64:0] exp);
    logic [64:0] got;
    int lat;
    run_op(op, off, imm, d, s, got, lat);
    check(req, got, exp);
  endtask

  function automatic logic [63:0] rnd64();
    case ($urandom % 8)
      0: return 64'h0;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h8000_0000_0000_0000;
      3: return {32'h0, $urandom % 64};
      4: return {$urandom, 32'h8000_0000};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [64:0] got, exp;
    int lat;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", {busy_o, done_o, illegal_o, result_o}, {3'b000, 62'h0});
    rst = 1'b0;

    // R1 class decode and immediate extension
    dir("R1", 8'h05, 0, 0, 64'd1, 64'd2, {1'b1, 64'h0});
    dir("R1", 8'h07, 0, 32'hFFFF_FFFF, 64'd1, 64'd0, {1'b0, 64'h0});
    dir("R1", 8'h04, 0, 32'hFFFF_FFFF, 64'd1, 64'd0, {1'b0, 64'h0});
    dir("R1", 8'h0F, 0, 32'd100, 64'd1, 64'd2, {1'b0, 64'd3});
    // R2 32-bit class clears upper half, NEG wraps
    dir("R2", 8'h1C, 0, 0, 64'hAAAA_0000_0000_0000, 64'd1, {1'b0, 64'h0000_0000_FFFF_FFFF});
    dir("R2", 8'h87, 0, 0, 64'h8000_0000_0000_0000, 0, {1'b0, 64'h8000_0000_0000_0000});
    dir("R2", 8'hB7, 0, 32'h8000_0000, 0, 0, {1'b0, 64'hFFFF_FFFF_8000_0000});
    // R3 shift masking and sign fill
    dir("R3", 8'h67, 0, 32'd65, 64'd1, 0, {1'b0, 64'd2});
    dir("R3", 8'h64, 0, 32'd33, 64'd1, 0, {1'b0, 64'd2});
    dir("R3", 8'hC4, 0, 32'd4, 64'hFFFF_FFFF_8000_0000, 0, {1'b0, 64'h0000_0000_F800_0000});
    dir("R3", 8'hC7, 0, 32'd63, 64'h8000_0000_0000_0000, 0, {1'b0, 64'hFFFF_FFFF_FFFF_FFFF});
    // R4 unsigned divide / modulo
    dir("R4", 8'h3F, 0, 0, 64'd100, 64'd7, {1'b0, 64'd14});
    dir("R4", 8'h37, 0, 32'hFFFF_FFFF, 64'd5, 0, {1'b0, 64'd0});
    dir("R4", 8'h94, 0, 32'd10, 64'hFFFF_FFFF_0000_0017, 0, {1'b0, 64'd3});
    // R5 signed truncation and wrap
    dir("R5", 8'h9F, 1, 0, -64'sd13, 64'd3, {1'b0, 64'hFFFF_FFFF_FFFF_FFFF});
    dir("R5", 8'h9C, 1, 0, 64'h1234_5678_FFFF_FFF3, 64'd3, {1'b0, 64'h0000_0000_FFFF_FFFF});
    dir("R5", 8'h3F, 1, 0, -64'sd13, 64'd3, {1'b0, 64'hFFFF_FFFF_FFFF_FFFC});
    dir("R5", 8'h3F, 1, 0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, {1'b0, 64'h8000_0000_0000_0000});
    dir("R5", 8'h9F, 1, 0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, {1'b0, 64'h0});
    dir("R5", 8'h3C, 1, 0, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF, {1'b0, 64'h0000_0000_8000_0000});
    // R6 divide / modulo by zero, one-cycle latency
    run_op(8'h37, 0, 0, 64'h1234, 0, got, lat);
    check("R6", {got, 1'b0}, {1'b0, 64'h0, 1'b0});
    check("R6 latency", 65'(lat), 65'd1);
    dir("R6", 8'h94, 0, 0, 64'hDEAD_BEEF_1234_5678, 0, {1'b0, 64'h0000_0000_1234_5678});
    dir("R6", 8'h9F, 1, 0, 64'hDEAD_BEEF_1234_5678, 0, {1'b0, 64'hDEAD_BEEF_1234_5678});
    // R7 sign-extending moves
    dir("R7", 8'hBF, 32, 0, 0, 64'h0000_0000_8000_0001, {1'b0, 64'hFFFF_FFFF_8000_0001});
    dir("R7", 8'hBC, 8, 0, 0, 64'h0000_0000_0000_0080, {1'b0, 64'h0000_0000_FFFF_FF80});
    dir("R7", 8'hBC, 32, 0, 0, 64'h1, {1'b1, 64'h0});
    dir("R7", 8'hB7, 16, 32'h1, 0, 64'h1, {1'b1, 64'h0});
    // R8 byte swaps
    dir("R8", 8'hDC, 0, 32'd16, 64'h1122_3344_5566_1234, 0, {1'b0, 64'h3412});
    dir("R8", 8'hD4, 0, 32'd32, 64'h1122_3344_5566_7788, 0, {1'b0, 64'h5566_7788});
    dir("R8", 8'hD4, 0, 32'd64, 64'h1122_3344_5566_7788, 0, {1'b0, 64'h1122_3344_5566_7788});
    dir("R8", 8'hD7, 0, 32'd64, 64'h1122_3344_5566_7788, 0, {1'b0, 64'h8877_6655_4433_2211});
    dir("R8", 8'hDF, 0, 32'd64, 64'h1, 0, {1'b1, 64'h0});
    // R9 illegal encodings
    dir("R9", 8'h8F, 0, 0, 64'd5, 64'd1, {1'b1, 64'h0});
    dir("R9", 8'hE7, 0, 0, 64'd5, 64'd1, {1'b1, 64'h0});
    dir("R9", 8'h0F, 1, 0, 64'd5, 64'd1, {1'b1, 64'h0});
    dir("R9", 8'hD7, 0, 32'd8, 64'd5, 0, {1'b1, 64'h0});

    // R10 start during divide is ignored, single done pulse
    @(negedge clk);
    opcode_i = 8'h3F; offset_i = 0; imm_i = 0; dst_i = 64'd1000; src_i = 64'd9; start_i = 1'b1;
    @(negedge clk);
    check("R10 busy", 65'(busy_o), 65'd1);
    opcode_i = 8'h0F; src_i = 64'd1;   // still busy: must be ignored
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 300) begin @(negedge clk); lat++; end
    check("R10 result", {illegal_o, result_o}, {1'b0, 64'd111});
    begin
      int extra = 0;
      repeat (4) begin @(negedge clk); if (done_o) extra++; end
      check("R10 no extra done", 65'(extra), 65'd0);
    end

    // random mix (R1..R10)
    for (int n = 0; n < 1500; n++) begin
      logic [7:0] op;
      logic [15:0] off;
      logic [31:0] imm;
      logic [63:0] d, s;
      logic divpath;
      op = {4'($urandom), 1'($urandom), ($urandom % 8 == 0) ? 3'($urandom) : (($urandom % 2) ? 3'h4 : 3'h7)};
      case ($urandom % 6)
        0, 1, 2: off = 0;
        3: off = 1;
        4: off = 16'(8 << ($urandom % 3));
        default: off = 16'($urandom);
      endcase
      case ($urandom % 5)
        0: imm = 32'(16 << ($urandom % 3));
        1: imm = 0;
        2: imm = $urandom % 70;
        default: imm = $urandom;
      endcase
      d = rnd64(); s = rnd64();
      exp = model(op, off, imm, d, s);
      divpath = !exp[64] && (op[7:4] == 4'h3 || op[7:4] == 4'h9) &&
                ((op[2:0] == 3'h4) ? ((op[3] ? s[31:0] : imm) != 0)
                                   : ((op[3] ? s : {{32{imm[31]}}, imm}) != 0));
      run_op(op, off, imm, d, s, got, lat);
      check($sformatf("R1..R9 random op=%h off=%0d", op, off), got, exp);
      if (!divpath) check("R10 one-cycle", 65'(lat), 65'd1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule